// File: doc/BRIEF.md
# DisplayPort Link Training Sequencer

This block is the source-side controller that brings a DisplayPort main link up. It talks to the sink through a one-byte-at-a-time AUX transaction port. A transaction is a write or read, a 20-bit address and a data byte, and the sink answers ACK, DEFER or NACK. After `start` the block programs the link rate and sends training pattern 1. It raises the lanes' voltage swing and pre-emphasis as the sink requests until every lane reports clock recovery. It then sends pattern 2 until the sink reports equalization, symbol lock and inter-lane alignment.

There are two counters for clock recovery attempts: one for all attempts, and one for consecutive attempts in which the sink asked for the same drive. When a phase gives up, the block drops the rate one step (5.4, then 2.7, then 1.62 Gbit/s) and restarts clock recovery. A status read that the sink defers is simply issued again. At the end the block turns the training pattern off and pulses `done`. With that pulse it presents the result, the final rate code and the packed per-lane drive levels.

Top module: `lt_seq`

## Requirements
- R1: After reset, `aux_req`, `done`, `pass` and `fail` are 0.
- R2: A run starts by writing 0x14 to address 0x100. Before each clock recovery attempt the current rate code is written to 0x100, and 0x21 (pattern 1, scrambling off) is then written to 0x102.
- R3: Lane i's drive byte is written to 0x103+i. The byte holds swing in bits 1:0 and pre-emphasis in bits 4:3. Bit 2 is 1 exactly when swing is 2, and bit 5 is 1 exactly when pre-emphasis is 2. A requested level of 3 is applied as 2.
- R4: Between the ACK of the last drive write and the first status read of 0x202, at least `WAIT_US` microseconds pass.
- R5: Each iteration reads the status bytes 0x202 onward, then 0x204, then the adjust bytes 0x206 onward. In a status nibble, bit 0 is clock recovery done, bit 1 is equalization done and bit 2 is symbol lock. Bit 0 of 0x204 is alignment done. In an adjust nibble, bits 1:0 are swing and bits 3:2 are pre-emphasis; lane 2k uses the low nibble of byte k and lane 2k+1 the high nibble. The next drive writes apply that request, including swing level 2.
- R6: Clock recovery gives up after `CR_MAX` (10) failed iterations in total, which means 10 lane-0 drive writes at that rate.
- R7: When the same request keeps arriving, `SAME_MAX` (5) identical requests are still applied. The next identical request gives up, so there are 6 lane-0 drive writes at that rate.
- R8: When clock recovery is done, 0x22 (pattern 2) is written to 0x102. Equalization gives up after `EQ_MAX` (5) failed iterations at one unchanged drive setting.
- R9: When a phase gives up, the rate steps 0x14 → 0x0A → 0x06 and training restarts from R2. If it gives up at 0x06, `fail` is set.
- R10: Up to `DEFER_MAX` (16) consecutive DEFERs of one transaction are retried, and they do not count as iterations.
- R11: A NACK, or DEFER number `DEFER_MAX`+1, ends training at the current rate as a give-up.
- R12: Every run ends with a write of 0x00 to 0x102. `done` is then high for exactly one cycle, with `pass`/`fail`, `rate` and `drive` (lane i swing in bits 4i+1:4i, pre-emphasis in bits 4i+3:4i+2) valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a training run (accepted when idle) |
| aux_req | output | 1 | Transaction requested; held until a response |
| aux_wr | output | 1 | 1 = write, 0 = read |
| aux_addr | output | 20 | Sink register address |
| aux_wdata | output | 8 | Write data |
| aux_rsp_valid | input | 1 | One-cycle response strobe |
| aux_rsp | input | 2 | 0 ACK, 1 NACK, 2 DEFER (3 treated as NACK) |
| aux_rdata | input | 8 | Read data, valid with an ACK |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Training succeeded |
| fail | output | 1 | Training failed at the lowest rate |
| rate | output | 8 | Current or final rate code |
| drive | output | 4*LANES | Packed per-lane drive levels |

## Verification
Several rules are checked on every cycle: the max-level flags in every drive byte, the one-cycle `done` pulse, legal rate codes, `pass` and `fail` never being high together, a quiet port when idle, status reads only after a wait, and failure only at the lowest rate. Only the bench scenarios can show the counting behaviour, using a sink model that logs drive writes per rate. Those scenarios cover the exact 6 and 10 attempt limits of clock recovery, the 5 tries of equalization, the rate stepping, DEFER transparency versus the DEFER cap and NACK, and the wait length.

// File: rtl/lt_seq.sv
module lt_seq #(
  parameter int LANES     = 2,
  parameter int CLK_MHZ   = 100,
  parameter int WAIT_US   = 200,
  parameter int DEFER_MAX = 16,
  parameter int CR_MAX    = 10,
  parameter int SAME_MAX  = 5,
  parameter int EQ_MAX    = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  output logic               aux_req,
  output logic               aux_wr,
  output logic [19:0]        aux_addr,
  output logic [7:0]         aux_wdata,
  input  logic               aux_rsp_valid,
  input  logic [1:0]         aux_rsp,
  input  logic [7:0]         aux_rdata,
  output logic               done,
  output logic               pass,
  output logic               fail,
  output logic [7:0]         rate,
  output logic [4*LANES-1:0] drive
);
  localparam int NS = (LANES + 1) / 2;
  localparam int NR = 2 * NS + 1;
  localparam int DW = 4 * LANES;
  localparam int IW = $clog2(LANES + NR);
  localparam int TW = $clog2(CR_MAX + 1);
  localparam int SW = $clog2(SAME_MAX + 2);
  localparam int EW = $clog2(EQ_MAX + 1);
  localparam int KW = $clog2(CLK_MHZ + 1);
  localparam int UW = $clog2(WAIT_US + 1);
  localparam int DCW = $clog2(DEFER_MAX + 2);
  localparam logic [IW-1:0] NS_I = IW'(NS);
  localparam logic [IW-1:0] AJ_I = IW'(NS + 1);

  typedef enum logic [2:0] {IDLE, W_RATE, W_PAT, W_LANE, WAIT, R_STAT, EVAL, W_OFF} st_t;
  st_t st;

  logic           eq_ph, have_last, pass_q, fail_q, done_q, align_q;
  logic [7:0]     rate_q;
  logic [DW-1:0]  drv_q, last_q, req_c;
  logic [NS*8-1:0] stat_q, adj_q;
  logic [IW-1:0]  idx;
  logic [TW-1:0]  tries;
  logic [SW-1:0]  same;
  logic [EW-1:0]  eqc;
  logic [KW-1:0]  tk;
  logic [UW-1:0]  us;
  logic [DCW-1:0] dcnt;
  logic           cr_ok, eq_ok, match, ack, bad, cr_give, eq_give, give;

  function automatic logic [1:0] cl(input logic [1:0] v);
    return (v == 2'b11) ? 2'b10 : v;
  endfunction

  function automatic logic [7:0] lset(input logic [3:0] d);
    return {2'b00, d[3:2] == 2'b10, d[3:2], d[1:0] == 2'b10, d[1:0]};
  endfunction

  always_comb begin
    cr_ok = 1'b1;
    eq_ok = align_q;
    for (int i = 0; i < LANES; i++) begin
      req_c[i*4 +: 4] = {cl(adj_q[i*4+2 +: 2]), cl(adj_q[i*4 +: 2])};
      cr_ok = cr_ok & stat_q[i*4];
      eq_ok = eq_ok & stat_q[i*4+1] & stat_q[i*4+2];
    end
  end

  assign aux_req = (st == W_RATE) || (st == W_PAT) || (st == W_LANE) || (st == R_STAT) || (st == W_OFF);
  assign aux_wr  = (st != R_STAT);

  always_comb begin
    aux_addr  = 20'h0;
    aux_wdata = 8'h00;
    case (st)
      W_RATE: begin aux_addr = 20'h100; aux_wdata = rate_q; end
      W_PAT:  begin aux_addr = 20'h102; aux_wdata = eq_ph ? 8'h22 : 8'h21; end
      W_OFF:  aux_addr = 20'h102;
      W_LANE: begin aux_addr = 20'h103 + 20'(idx); aux_wdata = lset(drv_q[int'(idx)*4 +: 4]); end
      R_STAT: aux_addr = (idx < NS_I) ? 20'h202 + 20'(idx) :
                         (idx == NS_I) ? 20'h204 : 20'h206 + 20'(idx - AJ_I);
      default: ;
    endcase
  end

  assign ack     = aux_rsp_valid && (aux_rsp == 2'b00);
  assign bad     = aux_rsp_valid && ((aux_rsp[0]) || (aux_rsp == 2'b10 && dcnt == DCW'(DEFER_MAX)));
  assign match   = have_last && (req_c == last_q);
  assign cr_give = !eq_ph && !cr_ok && ((tries >= TW'(CR_MAX - 1)) || (match && same >= SW'(SAME_MAX)));
  assign eq_give = eq_ph && (!cr_ok || (!eq_ok && req_c == drv_q && eqc >= EW'(EQ_MAX - 1)));
  assign give    = (aux_req && st != W_OFF && bad) || (st == EVAL && (cr_give || eq_give));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; eq_ph <= 1'b0; have_last <= 1'b0; pass_q <= 1'b0; fail_q <= 1'b0;
      done_q <= 1'b0; align_q <= 1'b0; rate_q <= 8'h14; drv_q <= '0; last_q <= '0;
      stat_q <= '0; adj_q <= '0; idx <= '0; tries <= '0; same <= '0; eqc <= '0;
      tk <= '0; us <= '0; dcnt <= '0;
    end else begin
      done_q <= 1'b0;
      if (aux_req && aux_rsp_valid)
        dcnt <= (aux_rsp == 2'b10) ? dcnt + 1'b1 : '0;
      if (give) begin
        dcnt  <= '0;
        eq_ph <= 1'b0;
        if (rate_q == 8'h06) begin
          fail_q <= 1'b1;
          st     <= W_OFF;
        end else begin
          rate_q <= (rate_q == 8'h14) ? 8'h0A : 8'h06;
          st     <= W_RATE;
        end
      end else begin
        case (st)
          IDLE: if (start) begin
            rate_q <= 8'h14; pass_q <= 1'b0; fail_q <= 1'b0; eq_ph <= 1'b0;
            dcnt <= '0; st <= W_RATE;
          end
          W_RATE: if (ack) begin
            drv_q <= '0; have_last <= 1'b0; tries <= '0; same <= '0; st <= W_PAT;
          end
          W_PAT: if (ack) begin idx <= '0; st <= W_LANE; end
          W_LANE: if (ack) begin
            if (idx == IW'(LANES - 1)) begin tk <= '0; us <= '0; st <= WAIT; end
            else idx <= idx + 1'b1;
          end
          WAIT: begin
            if (us == UW'(WAIT_US)) begin idx <= '0; st <= R_STAT; end
            else if (tk == KW'(CLK_MHZ - 1)) begin tk <= '0; us <= us + 1'b1; end
            else tk <= tk + 1'b1;
          end
          R_STAT: if (ack) begin
            if (idx < NS_I) stat_q[int'(idx)*8 +: 8] <= aux_rdata;
            else if (idx == NS_I) align_q <= aux_rdata[0];
            else adj_q[int'(idx - AJ_I)*8 +: 8] <= aux_rdata;
            if (idx == IW'(NR - 1)) st <= EVAL;
            else idx <= idx + 1'b1;
          end
          EVAL: begin
            idx <= '0;
            if (!eq_ph) begin
              if (cr_ok) begin eq_ph <= 1'b1; eqc <= '0; st <= W_PAT; end
              else begin
                tries <= tries + 1'b1; same <= match ? same + 1'b1 : SW'(1);
                last_q <= req_c; have_last <= 1'b1; drv_q <= req_c; st <= W_LANE;
              end
            end else if (eq_ok) begin
              pass_q <= 1'b1; st <= W_OFF;
            end else begin
              eqc <= (req_c == drv_q) ? eqc + 1'b1 : '0;
              drv_q <= req_c; st <= W_LANE;
            end
          end
          W_OFF: if (ack || bad) begin done_q <= 1'b1; st <= IDLE; end
          default: st <= IDLE;
        endcase
      end
    end
  end

  assign done  = done_q;
  assign pass  = pass_q;
  assign fail  = fail_q;
  assign rate  = rate_q;
  assign drive = drv_q;

  p_lane_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (aux_req && aux_wr && aux_addr >= 20'h103 && aux_addr < 20'h103 + 20'(LANES)) |->
      (aux_wdata[2] == (aux_wdata[1:0] == 2'b10)) && (aux_wdata[5] == (aux_wdata[4:3] == 2'b10)) &&
      (aux_wdata[1:0] != 2'b11) && (aux_wdata[4:3] != 2'b11));
  p_read_after_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == R_STAT && $past(st) != R_STAT) |-> $past(st) == WAIT);
  p_rate_legal_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rate_q == 8'h14 || rate_q == 8'h0A || rate_q == 8'h06);
  p_fail_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fail_q) |-> rate_q == 8'h06);
  p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  p_exclusive_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_q && fail_q));
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE) |-> !aux_req);
endmodule

// File: tb/lt_seq_tb.sv
module lt_seq_tb;
  localparam int LANES = 2;
  localparam int MHZ   = 50;
  localparam int WUS   = 4;

  logic clk = 0, rst_n = 0, start = 0;
  logic aux_req, aux_wr, rsp_v = 0, done, pass, fail;
  logic [19:0] aux_addr;
  logic [7:0] aux_wdata, rdata = 0, rate;
  logic [1:0] rsp = 0;
  logic [4*LANES-1:0] drive;

  always #10 clk = ~clk;

  lt_seq #(.LANES(LANES), .CLK_MHZ(MHZ), .WAIT_US(WUS)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .aux_req(aux_req), .aux_wr(aux_wr),
    .aux_addr(aux_addr), .aux_wdata(aux_wdata), .aux_rsp_valid(rsp_v), .aux_rsp(rsp),
    .aux_rdata(rdata), .done(done), .pass(pass), .fail(fail), .rate(rate), .drive(drive));

  int nchk = 0, nfail = 0, cyc = 0;
  logic [2:0] cr_mask, eq_mask;
  logic [1:0] tsw, tpe;
  logic alt, alt_t, nack_en, nack_done, pend, wr_flag;
  logic [7:0] nack_rate, cur_rate, first_rate, last_pat, last_l0;
  int defer_n, defer_left, lat, w14, w0a, w06, nrate, min_gap, last_wr;
  logic [19:0] p_addr; logic p_wr; logic [7:0] p_data;
  logic [3:0] ldrv [LANES];

  task automatic chk(input string req, input logic ok, input int act, input int exp);
    nchk++;
    if (!ok) begin nfail++; $display("FAIL %s actual=%0h expected=%0h", req, act, exp); end
  endtask

  function automatic int rb(input logic [7:0] r);
    return r == 8'h14 ? 2 : (r == 8'h0A ? 1 : 0);
  endfunction

  function automatic logic lane_cr(input int i);
    return cr_mask[rb(cur_rate)] && ldrv[i][1:0] == ((tsw == 2'b11) ? 2'b10 : tsw);
  endfunction

  function automatic logic [7:0] rd_val(input logic [19:0] a);
    logic all = lane_cr(0) && lane_cr(1);
    logic e = eq_mask[rb(cur_rate)] && all;
    logic [1:0] s = (alt && !cr_mask[rb(cur_rate)]) ? {1'b0, alt_t} : tsw;
    case (a)
      20'h202: return {1'b0, e, e, lane_cr(1), 1'b0, e, e, lane_cr(0)};
      20'h204: return {7'b0, e};
      20'h206: return {tpe, s, tpe, s};
      default: return 8'h00;
    endcase
  endfunction

  always @(negedge clk) begin
    cyc <= cyc + 1;
    rsp_v <= 1'b0;
    if (pend) begin
      if (lat > 0) lat <= lat - 1;
      else begin
        pend <= 1'b0; rsp_v <= 1'b1; rsp <= 2'b00;
        if (p_wr) begin
          last_wr <= cyc; wr_flag <= 1'b1;
          if (p_addr == 20'h100) begin
            cur_rate <= p_data; nrate <= nrate + 1;
            if (nrate == 0) first_rate <= p_data;
          end
          if (p_addr == 20'h102) begin last_pat <= p_data; defer_left <= defer_n; end
          if (p_addr >= 20'h103 && p_addr < 20'h103 + LANES) begin
            ldrv[p_addr - 20'h103] <= {p_data[4:3], p_data[1:0]};
            defer_left <= defer_n;
            if (p_addr == 20'h103) begin
              last_l0 <= p_data;
              if (cur_rate == 8'h14) w14 <= w14 + 1;
              else if (cur_rate == 8'h0A) w0a <= w0a + 1;
              else w06 <= w06 + 1;
            end
          end
        end else if (nack_en && !nack_done && p_addr == 20'h202 && cur_rate == nack_rate) begin
          rsp <= 2'b01; nack_done <= 1'b1;
        end else if (defer_left > 0) begin
          rsp <= 2'b10; defer_left <= defer_left - 1;
        end else begin
          rdata <= rd_val(p_addr);
          if (p_addr == 20'h206) alt_t <= ~alt_t;
        end
      end
    end else if (aux_req && !rsp_v) begin
      pend <= 1'b1; lat <= 1; p_addr <= aux_addr; p_wr <= aux_wr; p_data <= aux_wdata;
      if (!aux_wr && aux_addr == 20'h202 && wr_flag) begin
        wr_flag <= 1'b0;
        if (cyc - last_wr < min_gap) min_gap <= cyc - last_wr;
      end
    end
    if (cyc > 190000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic setup(input logic [2:0] crm, input logic [2:0] eqm, input logic [1:0] s,
                       input logic [1:0] p, input logic a, input int dn, input logic ne);
    @(negedge clk);
    cr_mask = crm; eq_mask = eqm; tsw = s; tpe = p; alt = a; alt_t = 0; defer_n = dn;
    nack_en = ne; nack_done = 0; nack_rate = 8'h14; w14 = 0; w0a = 0; w06 = 0; nrate = 0;
    min_gap = 1000000; defer_left = 0; wr_flag = 0; last_pat = 8'hFF;
  endtask

  logic r_pass, r_fail, r_after; logic [7:0] r_rate; logic [4*LANES-1:0] r_drv;

  task automatic run();
    int n = 0;
    start = 1; @(negedge clk); start = 0;
    while (!done && n < 60000) begin @(negedge clk); n++; end
    r_pass = pass; r_fail = fail; r_rate = rate; r_drv = drive;
    @(negedge clk); r_after = done;
    chk("R12 done pulse", r_after == 0 && n < 60000, r_after, 0);
    chk("R12 pattern off", last_pat == 8'h00, last_pat, 0);
  endtask

  task automatic t_reset();
    chk("R1 reset idle", !aux_req && !done && !pass && !fail, {aux_req, done, pass, fail}, 0);
  endtask

  task automatic t_normal();
    setup(3'b111, 3'b111, 2'd2, 2'd1, 0, 16, 0);
    run();
    chk("R2 first rate", first_rate == 8'h14, first_rate, 8'h14);
    chk("R10 pass with deferrals", r_pass && !r_fail && r_rate == 8'h14, r_rate, 8'h14);
    chk("R5 drive level 2 applied", r_drv == 8'h66, r_drv, 8'h66);
    chk("R3 lane byte flags", last_l0 == 8'h0E, last_l0, 8'h0E);
    chk("R10 deferrals not counted", w14 == 3, w14, 3);
    chk("R4 wait length", min_gap >= WUS * MHZ, min_gap, WUS * MHZ);
  endtask

  task automatic t_clamp();
    setup(3'b111, 3'b111, 2'd3, 2'd3, 0, 0, 0);
    run();
    chk("R3 clamp drive", r_pass && r_drv == 8'hAA, r_drv, 8'hAA);
    chk("R3 clamp lane byte", last_l0 == 8'h36, last_l0, 8'h36);
  endtask

  task automatic t_same();
    setup(3'b011, 3'b111, 2'd1, 2'd0, 0, 0, 0);
    run();
    chk("R7 identical requests applied", w14 == 6, w14, 6);
    chk("R9 pass after step", r_pass && r_rate == 8'h0A, r_rate, 8'h0A);
  endtask

  task automatic t_total();
    setup(3'b011, 3'b111, 2'd1, 2'd0, 1, 0, 0);
    run();
    chk("R6 total attempt cap", w14 == 10, w14, 10);
    chk("R6 recovered at next rate", r_pass && r_rate == 8'h0A, r_rate, 8'h0A);
  endtask

  task automatic t_eq();
    setup(3'b111, 3'b001, 2'd1, 2'd0, 0, 0, 0);
    run();
    chk("R8 eq tries at HBR2", w14 == 7, w14, 7);
    chk("R8 eq tries at HBR", w0a == 7, w0a, 7);
    chk("R9 pass at lowest", r_pass && r_rate == 8'h06, r_rate, 8'h06);
  endtask

  task automatic t_fail();
    setup(3'b000, 3'b000, 2'd1, 2'd0, 0, 0, 0);
    run();
    chk("R9 fail at lowest", r_fail && !r_pass && r_rate == 8'h06, {r_fail, r_rate}, 9'h106);
    chk("R2 rate programmed per step", nrate == 3, nrate, 3);
  endtask

  task automatic t_nack();
    setup(3'b111, 3'b111, 2'd1, 2'd0, 0, 0, 1);
    run();
    chk("R11 nack gives up", w14 == 1 && r_pass && r_rate == 8'h0A, {w14, r_rate}, 8'h0A);
  endtask

  task automatic t_defcap();
    setup(3'b111, 3'b111, 2'd1, 2'd0, 0, 17, 0);
    run();
    chk("R11 defer cap", r_fail && w14 == 1 && w06 == 1, {w14, w06}, 2);
  endtask

  initial begin
    pend = 0; cur_rate = 8'h00; first_rate = 0; last_l0 = 0; last_wr = 0;
    for (int i = 0; i < LANES; i++) ldrv[i] = 4'h0;
    setup(3'b111, 3'b111, 2'd0, 2'd0, 0, 0, 0);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_normal();
    t_clamp();
    t_same();
    t_total();
    t_eq();
    t_fail();
    t_nack();
    t_defcap();
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule